// File: doc/BRIEF.md
# Keyed Configuration Write Guard

This block sits in front of a peripheral's register bank. It decides, for every write on a plain address/data port, whether the bank may accept that write. It does this through a one-bit permit output, `wr_permit`. The guard owns two registers of its own: a lock mode register and a violation status register.

Setting or clearing the lock bit needs a fixed 24-bit key in the upper bits of the same write. While the lock is on, writes to the low configuration window are refused. The first refused address is latched together with a violation flag, and reading the status register returns both and clears them. Addresses above the configuration window hold status, command and interrupt-enable registers, which stay writable at all times.

The guard is a four-state machine:
- `ST_OPEN_CLEAN`: unlocked, no violation.
- `ST_OPEN_FLAG`: unlocked, violation pending.
- `ST_LOCK_CLEAN`: locked, no violation.
- `ST_LOCK_FLAG`: locked, violation pending.

Its transitions are:
- **lock**: a keyed write with bit 0 set. `OPEN_CLEAN` to `LOCK_CLEAN`, and `OPEN_FLAG` to `LOCK_FLAG`.
- **unlock**: a keyed write with bit 0 clear. `LOCK_CLEAN` to `OPEN_CLEAN`, and `LOCK_FLAG` to `OPEN_FLAG`.
- **refuse**: a write to the configuration window while locked. `LOCK_CLEAN` to `LOCK_FLAG`.
- **acknowledge**: a read of the status register. `OPEN_FLAG` to `OPEN_CLEAN`, and `LOCK_FLAG` to `LOCK_CLEAN`.

Top module: `wr_guard`

## Requirements
- R1: After reset the lock is off, no violation is pending, both guard registers read as zero, and `wr_permit` is low while `wr_en` is low.
- R2: A write to the mode register (address 0xE4) whose bits 31:8 equal 0x54494D loads bit 0 of the write data into the lock bit, effective from the next cycle.
- R3: A write to the mode register with any other value in bits 31:8 leaves the lock bit unchanged and records no violation.
- R4: A read of the mode register returns the lock bit in bit 0, with bits 31:1 always zero (the key is never returned).
- R5: Addresses below 0x40 form the configuration window. A write there gets `wr_permit` high when unlocked and low when locked.
- R6: Addresses from 0x40 to 0xFF, other than the two guard registers, get `wr_permit` equal to `wr_en` whatever the lock state.
- R7: A refused write sets the violation flag (status bit 0) and latches the refused address into status bits 15:8.
- R8: A read of the status register (address 0xE8) returns the current flag and address, then clears both, so the next read returns zero.
- R9: While the flag is set, further refused writes do not replace the latched address; the first offender is kept.
- R10: `wr_permit` is never high for the two guard registers' addresses, and writes to the status register have no effect.
- R11: Read data appears on `rdata` in the cycle after `rd_en` and is zero in every other cycle. When `wr_en` and `rd_en` are high together, the write is performed and the read is ignored (no data, no clear).
- R12: Unlocking does not clear a pending violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data of the guard registers |
| wr_permit | output | 1 | Current write may be taken by the register bank |

## Verification
The bench checks that a key one bit off from the correct one leaves the lock alone. A design comparing only part of the key field would lock here. It checks that a second refused write while the flag is pending keeps the first address; a design that always overwrites would report the latest offender. It covers a write and a read issued together to the status register, where a design that let the read through would lose a pending violation. It covers unlocking with a violation outstanding, where a design tying the flag to the lock would drop it. The boundary addresses 0x3F and 0x40 are probed in both lock states, so a window comparison that is off by one shows up as a permit mismatch.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;

    typedef enum logic [1:0] {
        ST_OPEN_CLEAN = 2'd0,
        ST_OPEN_FLAG  = 2'd1,
        ST_LOCK_CLEAN = 2'd2,
        ST_LOCK_FLAG  = 2'd3
    } guard_state_e;

    typedef enum logic [1:0] {
        AC_CFG  = 2'd0,
        AC_FREE = 2'd1,
        AC_MODE = 2'd2,
        AC_STAT = 2'd3
    } access_class_e;

endpackage

// File: rtl/wr_guard_decode.sv
module wr_guard_decode
    import wr_guard_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 32,
    parameter int                 KEY_W     = 24,
    parameter logic [KEY_W-1:0]   KEY       = 24'h54494D,
    parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'hE4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 8'hE8,
    parameter logic [ADDR_W-1:0]  CFG_LIMIT = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output access_class_e     acc_class,
    output logic              key_ok,
    output logic              new_lock
);
    localparam int KEY_LSB = DATA_W - KEY_W;

    // Address classification: the two guard registers take precedence over
    // the window comparison.
    always_comb begin
        if (addr == MODE_ADDR) begin
            acc_class = AC_MODE;
        end else if (addr == STAT_ADDR) begin
            acc_class = AC_STAT;
        end else if (addr < CFG_LIMIT) begin
            acc_class = AC_CFG;
        end else begin
            acc_class = AC_FREE;
        end
    end

    // The full key field is compared; bit 0 carries the requested lock value.
    assign key_ok   = (wdata[DATA_W-1:KEY_LSB] == KEY);
    assign new_lock = wdata[0];

    logic unused_mid_bits;
    assign unused_mid_bits = ^wdata[KEY_LSB-1:1];

endmodule

// File: rtl/wr_guard_fsm.sv
module wr_guard_fsm
    import wr_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  access_class_e     acc_class,
    input  logic              key_ok,
    input  logic              new_lock,
    output logic              locked,
    output logic              flagged,
    output logic [ADDR_W-1:0] cap_addr
);
    guard_state_e state_q, state_d;
    logic         key_wr;
    logic         refused;
    logic         stat_rd;

    assign key_wr  = wr_en && (acc_class == AC_MODE) && key_ok;
    assign refused = wr_en && (acc_class == AC_CFG) && locked;
    assign stat_rd = rd_en && !wr_en && (acc_class == AC_STAT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPEN_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN_CLEAN: begin
                if (key_wr && new_lock) state_d = ST_LOCK_CLEAN;
            end
            ST_OPEN_FLAG: begin
                if (key_wr && new_lock) state_d = ST_LOCK_FLAG;
                else if (stat_rd)       state_d = ST_OPEN_CLEAN;
            end
            ST_LOCK_CLEAN: begin
                if (key_wr && !new_lock) state_d = ST_OPEN_CLEAN;
                else if (refused)        state_d = ST_LOCK_FLAG;
            end
            ST_LOCK_FLAG: begin
                if (key_wr && !new_lock) state_d = ST_OPEN_FLAG;
                else if (stat_rd)        state_d = ST_LOCK_CLEAN;
            end
            default: state_d = ST_OPEN_CLEAN;
        endcase
    end

    // State-derived outputs
    always_comb begin
        locked  = 1'b0;
        flagged = 1'b0;
        unique case (state_q)
            ST_OPEN_CLEAN: begin locked = 1'b0; flagged = 1'b0; end
            ST_OPEN_FLAG:  begin locked = 1'b0; flagged = 1'b1; end
            ST_LOCK_CLEAN: begin locked = 1'b1; flagged = 1'b0; end
            ST_LOCK_FLAG:  begin locked = 1'b1; flagged = 1'b1; end
            default:       begin locked = 1'b0; flagged = 1'b0; end
        endcase
    end

    // Offending address: taken only on the refuse transition, dropped on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
        end else if (stat_rd) begin
            cap_addr <= '0;
        end else if (state_q == ST_LOCK_CLEAN && refused) begin
            cap_addr <= addr;
        end
    end

    a_r2_key_loads_lock: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (locked == $past(new_lock)));

    a_r3_bad_key_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && acc_class == AC_MODE && !key_ok) |=> $stable(locked));

    a_r7_refuse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> flagged);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (!flagged && cap_addr == '0));

    a_r9_first_offender_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (flagged && !stat_rd) |=> (flagged && $stable(cap_addr)));

endmodule

// File: rtl/wr_guard_readback.sv
module wr_guard_readback
    import wr_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  access_class_e     acc_class,
    input  logic              locked,
    input  logic              flagged,
    input  logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int CAP_LSB = 8;

    logic [DATA_W-1:0] mode_word;
    logic [DATA_W-1:0] stat_word;
    logic              rd_take;

    assign rd_take = rd_en && !wr_en;

    always_comb begin
        mode_word    = '0;
        mode_word[0] = locked;
        stat_word    = '0;
        stat_word[0] = flagged;
        stat_word[CAP_LSB +: ADDR_W] = cap_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_take && acc_class == AC_MODE) begin
            rdata <= mode_word;
        end else if (rd_take && acc_class == AC_STAT) begin
            rdata <= stat_word;
        end else begin
            rdata <= '0;
        end
    end

    a_r11_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> (rdata == '0));

    a_r4_key_never_returned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && acc_class == AC_MODE) |=> (rdata[DATA_W-1:1] == '0));

endmodule

// File: rtl/wr_guard.sv
module wr_guard
    import wr_guard_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 32,
    parameter int                 KEY_W     = 24,
    parameter logic [KEY_W-1:0]   KEY       = 24'h54494D,
    parameter logic [ADDR_W-1:0]  MODE_ADDR = 8'hE4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = 8'hE8,
    parameter logic [ADDR_W-1:0]  CFG_LIMIT = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_permit
);
    access_class_e     acc_class;
    logic              key_ok;
    logic              new_lock;
    logic              locked;
    logic              flagged;
    logic [ADDR_W-1:0] cap_addr;

    wr_guard_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY(KEY),
        .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR), .CFG_LIMIT(CFG_LIMIT)
    ) u_decode (
        .addr(addr), .wdata(wdata),
        .acc_class(acc_class), .key_ok(key_ok), .new_lock(new_lock)
    );

    wr_guard_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .acc_class(acc_class), .key_ok(key_ok), .new_lock(new_lock),
        .locked(locked), .flagged(flagged), .cap_addr(cap_addr)
    );

    wr_guard_readback #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_readback (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .acc_class(acc_class), .locked(locked), .flagged(flagged),
        .cap_addr(cap_addr), .rdata(rdata)
    );

    // Bank permit: free window always, configuration window only while unlocked
    always_comb begin
        wr_permit = 1'b0;
        if (wr_en) begin
            unique case (acc_class)
                AC_FREE: wr_permit = 1'b1;
                AC_CFG:  wr_permit = !locked;
                AC_MODE: wr_permit = 1'b0;
                AC_STAT: wr_permit = 1'b0;
                default: wr_permit = 1'b0;
            endcase
        end
    end

    a_r5_locked_window_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr < CFG_LIMIT) |-> !wr_permit);

    a_r10_permit_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> (wr_en && addr != MODE_ADDR && addr != STAT_ADDR));

    a_r6_free_window_open: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= CFG_LIMIT && addr != MODE_ADDR && addr != STAT_ADDR) |-> wr_permit);

endmodule

// File: tb/wr_guard_tb.sv
module wr_guard_tb;
    localparam logic [7:0]  MODE = 8'hE4;
    localparam logic [7:0]  STAT = 8'hE8;
    localparam logic [7:0]  CFG  = 8'h40;
    localparam logic [23:0] GOOD = 24'h54494D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        wr_permit;

    int    errors = 0;
    int    checks = 0;
    string phase = "R1";

    // Behavioural reference state
    bit          m_lock;
    bit          m_flag;
    logic [7:0]  m_cap;
    logic [31:0] m_rdata;

    wr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wr_permit(wr_permit)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_flag = 0; m_cap = '0; m_rdata = '0;
        end else if (wr_en) begin
            m_rdata = '0;
            if (addr == MODE && wdata[31:8] == GOOD) begin
                m_lock = wdata[0];
            end else if (addr < CFG && m_lock && !m_flag) begin
                m_flag = 1; m_cap = addr;
            end
        end else if (rd_en) begin
            if (addr == MODE) begin
                m_rdata = {31'b0, m_lock};
            end else if (addr == STAT) begin
                m_rdata = {16'b0, m_cap, 7'b0, m_flag};
                m_flag = 0; m_cap = '0;
            end else begin
                m_rdata = '0;
            end
        end else begin
            m_rdata = '0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic step(bit w, bit r, logic [7:0] a, logic [31:0] d);
        logic  exp_permit;
        string tag;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        exp_permit = w && a != MODE && a != STAT && !(m_lock && a < CFG);
        if (a == MODE || a == STAT) tag = "R10";
        else if (a < CFG)           tag = "R5";
        else                        tag = "R6";
        check(tag, {31'b0, wr_permit}, {31'b0, exp_permit});
        check(phase, rdata, m_rdata);
    endtask

    task automatic idle();
        step(0, 0, 8'h00, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        phase = "R1";
        idle();
        check("R1", {31'b0, wr_permit}, 32'h0);
        step(0, 1, MODE, 0); idle(); check("R1", rdata, 32'h0);
        step(0, 1, STAT, 0); idle(); check("R1", rdata, 32'h0);

        // R5/R6 unlocked window
        phase = "R5";
        step(1, 0, 8'h10, 32'hA5); step(1, 0, 8'h3F, 32'h1); step(1, 0, 8'h40, 32'h2);

        // R3: wrong key (one bit off) leaves lock off
        phase = "R3";
        step(1, 0, MODE, {24'h54494C, 8'h01});
        step(0, 1, MODE, 0); idle(); check("R3", rdata, 32'h0);
        step(0, 1, STAT, 0); idle(); check("R3", rdata, 32'h0);

        // R2/R4: keyed lock, readback shows only bit 0
        phase = "R2";
        step(1, 0, MODE, {GOOD, 8'hFF});
        step(0, 1, MODE, 0); idle(); check("R4", rdata, 32'h1);

        // R5/R7: refused write captured
        phase = "R7";
        step(1, 0, 8'h3F, 32'h0);
        step(1, 0, 8'h40, 32'h0);
        step(0, 1, STAT, 0); idle(); check("R7", rdata, 32'h0000_3F01);
        phase = "R8";
        step(0, 1, STAT, 0); idle(); check("R8", rdata, 32'h0);

        // R9: first offender kept
        phase = "R9";
        step(1, 0, 8'h20, 32'h0); step(1, 0, 8'h3C, 32'h0);
        step(0, 1, STAT, 0); idle(); check("R9", rdata, 32'h0000_2001);

        // R10: status write has no effect, no permit
        phase = "R10";
        step(1, 0, STAT, 32'hFFFF_FFFF);
        step(0, 1, STAT, 0); idle(); check("R10", rdata, 32'h0);

        // R11: write and read together -> write wins, read ignored
        phase = "R11";
        step(1, 0, 8'h30, 32'h0);
        step(1, 1, STAT, 32'h0); idle(); check("R11", rdata, 32'h0);
        step(0, 1, STAT, 0); idle(); check("R11", rdata, 32'h0000_3001);

        // R12: unlock keeps a pending violation
        phase = "R12";
        step(1, 0, 8'h08, 32'h0);
        step(1, 0, MODE, {GOOD, 8'h00});
        step(1, 0, 8'h08, 32'h0);
        check("R12", {31'b0, wr_permit}, 32'h1);
        step(0, 1, STAT, 0); idle(); check("R12", rdata, 32'h0000_0801);
        step(0, 1, MODE, 0); idle(); check("R12", rdata, 32'h0);

        // Mixed sweep against the reference model
        phase = "R11";
        for (int i = 0; i < 96; i++) begin
            logic [7:0] a;
            a = 8'((i * 37) & 8'hFF);
            if (i % 16 == 0) step(1, 0, MODE, {GOOD, 7'b0, 1'(i / 16 % 2)});
            else if (i % 11 == 0) step(0, 1, STAT, 0);
            else if (i % 7 == 0) step(0, 1, MODE, 0);
            else step(1, 0, a, 32'(i));
        end
        idle();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule